// File: doc/BRIEF.md
# Flash Burst FIFO Engine

This block sits between a host register port and a simple synchronous flash word port. It moves whole 32-bit words between them through one shared word FIFO. To read, the host first loads a flash word address. It then writes the control register with a word count and the read-mode bit set. The engine raises busy and fetches that many consecutive words into the FIFO. Busy drops once the last word has landed. The host then drains the words one per read of the data port.

When the engine is not in read mode, every host write to the data port queues one word. The engine writes queued words to flash at consecutive addresses, one per cycle. The control register reports how many FIFO entries are free, so the host can pace its writes. Writing the control register with the read-mode bit clear ends a read, empties the FIFO and returns the engine to idle.

Top module: `fbf_engine`

## Requirements
- R1: After reset, busy and read-mode are 0, the control register reads 0x0010_0000 (free space 16 with the default depth of 16), a data-port read returns 0, and no flash access is issued.
- R2: Register select 0 is control, 1 is the flash word address and 2 is the FIFO data port. A control write carries the read-mode bit in bit 0 and the word count in bits 15:8. A control read returns read-mode in bit 0, busy in bit 1, the last accepted count in bits 15:8 and the free FIFO entries in bits 31:16. An address read returns the current word address.
- R3: An accepted read issues exactly count flash reads, one per cycle. They go to consecutive word addresses, starting at the loaded address.
- R4: Busy is set from the cycle after an accepted read start. It clears only once all requested words are stored in the FIFO.
- R5: Each data-port read in read mode returns the next fetched word in address order, on the read data output one cycle after the strobe.
- R6: A data-port read while the FIFO is empty returns 0 and leaves the FIFO contents and free-space count unchanged.
- R7: A read start whose count is 0 or larger than the FIFO depth is rejected: busy and read-mode stay 0 and no flash read is issued.
- R8: A control write with bit 0 clear ends any read at once. Busy and read-mode go to 0, flash reads stop and the FIFO is emptied.
- R9: Outside read mode, each data-port write pushes one word. The engine writes the words to flash in order, with write enable high, at consecutive addresses from the loaded address.
- R10: The free-space field equals the FIFO depth minus the words held. It equals the full depth when the FIFO is empty and 0 when a full-depth read has completed.
- R11: A read start written while busy is ignored. The running read and its count are unaffected.
- R12: Flash read data is taken exactly one cycle after the matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 data port |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data, valid the cycle after host_rd |
| flash_req | output | 1 | Flash access request |
| flash_we | output | 1 | Flash write enable, 0 for a read |
| flash_addr | output | FADDR_W | Flash word address |
| flash_wdata | output | 32 | Flash write data |
| flash_rdata | input | 32 | Flash read data, valid one cycle after a read request |

## Verification
The bench runs bursts of 1, 4 and the full depth of 16 words and compares each popped word with the model's data for its address. A design that pushed flash data on the wrong cycle, or skipped an address, would return shifted or repeated words. It starts reads with counts of 0 and 17, which must be refused. An off-by-one count check would either hang with busy set or fetch a stray burst. It pops an empty FIFO and then checks that the free-space count is unchanged. A design that moved its pointers on an empty pop would report the wrong free space or hand out stale words later. It also aborts a burst mid-flight and sends a second start while the first is busy. An engine that kept fetching after the abort, or let the second start restart the first, would show extra flash reads or the wrong count field.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  localparam int FBF_WORD_W  = 32;
  localparam int FBF_CNT_LSB = 8;
  localparam int FBF_CNT_W   = 8;
  localparam int FBF_SPC_LSB = 16;
  localparam int FBF_SPC_W   = 16;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2
  } fbf_sel_e;

  // a burst length is legal when it is non-zero and fits the FIFO
  function automatic logic fbf_count_ok(input logic [FBF_CNT_W-1:0] cnt,
                                        input int depth);
    return (cnt != '0) && (int'(cnt) <= depth);
  endfunction

  function automatic logic [FBF_SPC_W-1:0] fbf_free_words(input int used,
                                                          input int depth);
    return FBF_SPC_W'(depth - used);
  endfunction

  function automatic logic [FBF_WORD_W-1:0] fbf_ctrl_word(
      input logic                 mode,
      input logic                 busy,
      input logic [FBF_CNT_W-1:0] cnt,
      input logic [FBF_SPC_W-1:0] space);
    return {space, cnt, 6'b0, busy, mode};
  endfunction

endpackage

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          push,
  input  logic [W-1:0]                  wdata,
  input  logic                          pop,
  output logic [W-1:0]                  head,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(DEPTH+1)-1:0]    used
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int UW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [UW-1:0] used_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (used_q == '0);
  assign full    = (int'(used_q) == DEPTH);
  assign used    = used_q;
  assign head    = mem[rptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr   <= '0;
      rptr   <= '0;
      used_q <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      case ({do_push, do_pop})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  // R9: the engine must never push into a full FIFO
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6: popping an empty FIFO leaves it empty
  a_r6_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (used == '0));

endmodule

// File: rtl/fbf_seq.sv
module fbf_seq
  import fbf_pkg::*;
#(
  parameter int FADDR_W = 24,
  parameter int DEPTH   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  input  logic                  stop_req,
  input  logic [FBF_CNT_W-1:0]  cnt_in,
  input  logic                  addr_wr,
  input  logic [FADDR_W-1:0]    addr_in,
  input  logic                  fifo_has_data,
  input  logic [FBF_WORD_W-1:0] fifo_head,
  output logic                  drain_pop,
  output logic                  fill_push,
  output logic [FBF_WORD_W-1:0] fill_data,
  output logic                  start_ok,
  output logic                  rd_mode,
  output logic                  busy,
  output logic [FBF_CNT_W-1:0]  cnt_latched,
  output logic [FADDR_W-1:0]    cur_addr,
  output logic                  flash_req,
  output logic                  flash_we,
  output logic [FADDR_W-1:0]    flash_addr,
  output logic [FBF_WORD_W-1:0] flash_wdata,
  input  logic [FBF_WORD_W-1:0] flash_rdata
);
  logic                 mode_q, busy_q, pend_q;
  logic [FBF_CNT_W-1:0] cnt_q, issued_q, recv_q;
  logic [FADDR_W-1:0]   addr_q;
  logic                 rd_issue, wr_issue, last_word;

  always_comb begin
    start_ok    = start_req && !busy_q && fbf_count_ok(cnt_in, DEPTH);
    rd_issue    = busy_q && !stop_req && (issued_q != cnt_q);
    wr_issue    = !mode_q && !start_req && !stop_req && fifo_has_data;
    fill_push   = pend_q && busy_q && !stop_req;
    last_word   = fill_push && ((recv_q + 1'b1) == cnt_q);
    fill_data   = flash_rdata;
    drain_pop   = wr_issue;
    flash_req   = rd_issue || wr_issue;
    flash_we    = wr_issue;
    flash_addr  = addr_q;
    flash_wdata = wr_issue ? fifo_head : '0;
    rd_mode     = mode_q;
    busy        = busy_q;
    cnt_latched = cnt_q;
    cur_addr    = addr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      issued_q <= '0;
      recv_q   <= '0;
      addr_q   <= '0;
    end else begin
      if (addr_wr)        addr_q <= addr_in;
      else if (flash_req) addr_q <= addr_q + 1'b1;

      if (stop_req) begin
        mode_q <= 1'b0;
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (start_ok) begin
        mode_q   <= 1'b1;
        busy_q   <= 1'b1;
        cnt_q    <= cnt_in;
        issued_q <= '0;
        recv_q   <= '0;
        pend_q   <= 1'b0;
      end else begin
        pend_q <= rd_issue;
        if (rd_issue)  issued_q <= issued_q + 1'b1;
        if (fill_push) recv_q   <= recv_q + 1'b1;
        if (last_word) busy_q   <= 1'b0;
      end
    end
  end

  // R12: fetched data enters the FIFO exactly one cycle after its request
  a_r12_fill_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    fill_push |-> $past(rd_issue));

  // R4: busy only drops by itself right after the final word was stored
  a_r4_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(stop_req)) |-> $past(fill_push));

  // R8: an abort leaves the engine idle on the next cycle
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!busy_q && !mode_q));

  // R7: no flash read is ever issued while not busy
  a_r7_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !(flash_req && !flash_we));

  // R3: back-to-back accesses walk consecutive word addresses
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req && $past(flash_req) && !$past(addr_wr))
      |-> (flash_addr == $past(flash_addr) + 1'b1));

endmodule

// File: rtl/fbf_engine.sv
module fbf_engine
  import fbf_pkg::*;
#(
  parameter int FADDR_W = 24,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [1:0]         host_sel,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               flash_req,
  output logic               flash_we,
  output logic [FADDR_W-1:0] flash_addr,
  output logic [31:0]        flash_wdata,
  input  logic [31:0]        flash_rdata
);
  localparam int UW = $clog2(DEPTH + 1);

  logic                 ctl_wr, start_req, stop_req, addr_wr;
  logic                 host_push, host_pop;
  logic                 fill_push, drain_pop, start_ok, flush;
  logic                 rd_mode, busy;
  logic [31:0]          fill_data, fifo_head, fifo_wdata;
  logic                 fifo_empty, fifo_full, fifo_push, fifo_pop;
  logic [UW-1:0]        fifo_used;
  logic [FBF_CNT_W-1:0] cnt_latched;
  logic [FADDR_W-1:0]   cur_addr;
  logic [FBF_SPC_W-1:0] free_words;

  // host side decode, brought out as named events
  assign ctl_wr     = host_wr && (host_sel == SEL_CTRL);
  assign start_req  = ctl_wr && host_wdata[0];
  assign stop_req   = ctl_wr && !host_wdata[0];
  assign addr_wr    = host_wr && (host_sel == SEL_ADDR);
  assign host_push  = host_wr && (host_sel == SEL_DATA) && !rd_mode && !fifo_full
                      && !stop_req;
  assign host_pop   = host_rd && (host_sel == SEL_DATA) && rd_mode && !fifo_empty;
  assign flush      = stop_req || start_ok;
  assign fifo_push  = fill_push || host_push;
  assign fifo_wdata = fill_push ? fill_data : host_wdata;
  assign fifo_pop   = drain_pop || host_pop;
  assign free_words = fbf_free_words(int'(fifo_used), DEPTH);

  fbf_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (fifo_push),
    .wdata (fifo_wdata),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full),
    .used  (fifo_used)
  );

  fbf_seq #(.FADDR_W(FADDR_W), .DEPTH(DEPTH)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .cnt_in        (host_wdata[FBF_CNT_LSB +: FBF_CNT_W]),
    .addr_wr       (addr_wr),
    .addr_in       (host_wdata[FADDR_W-1:0]),
    .fifo_has_data (!fifo_empty),
    .fifo_head     (fifo_head),
    .drain_pop     (drain_pop),
    .fill_push     (fill_push),
    .fill_data     (fill_data),
    .start_ok      (start_ok),
    .rd_mode       (rd_mode),
    .busy          (busy),
    .cnt_latched   (cnt_latched),
    .cur_addr      (cur_addr),
    .flash_req     (flash_req),
    .flash_we      (flash_we),
    .flash_addr    (flash_addr),
    .flash_wdata   (flash_wdata),
    .flash_rdata   (flash_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_sel)
        SEL_CTRL: host_rdata <= fbf_ctrl_word(rd_mode, busy, cnt_latched, free_words);
        SEL_ADDR: host_rdata <= 32'(cur_addr);
        SEL_DATA: host_rdata <= (rd_mode && !fifo_empty) ? fifo_head : '0;
        default:  host_rdata <= '0;
      endcase
    end
  end

  // R6: an empty pop returns zero on the next cycle
  a_r6_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == SEL_DATA && fifo_empty) |=> (host_rdata == '0));

  // R10: the FIFO never holds more than its depth
  a_r10_space_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_used) <= DEPTH);

endmodule

// File: tb/tb_fbf_engine.sv
module tb_fbf_engine;
  localparam int DEPTH   = 16;
  localparam int FADDR_W = 24;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]         host_sel = '0;
  logic [31:0]        host_wdata = '0;
  logic [31:0]        host_rdata;
  logic               flash_req, flash_we;
  logic [FADDR_W-1:0] flash_addr;
  logic [31:0]        flash_wdata;
  logic [31:0]        flash_rdata = '0;

  int n_checks = 0, n_fail = 0;
  int rd_cnt = 0, rd_mism = 0, wr_cnt = 0;
  logic [FADDR_W-1:0] exp_rd_addr = '0;
  logic [31:0]        wr_data_log [8];
  logic [FADDR_W-1:0] wr_addr_log [8];

  always #5 clk = ~clk;

  fbf_engine #(.FADDR_W(FADDR_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .flash_req(flash_req), .flash_we(flash_we), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_rdata(flash_rdata)
  );

  function automatic logic [31:0] fword(input logic [FADDR_W-1:0] a);
    return {8'h5A, a} ^ 32'h0F0F_3C00;
  endfunction

  function automatic logic [31:0] ctrl_exp(input int mode, input int busy,
                                           input int cnt, input int used);
    logic [31:0] v;
    v = 32'((DEPTH - used) * 65536 + cnt * 256 + busy * 2 + mode);
    return v;
  endfunction

  // flash model: one-cycle read latency, logs reads and writes
  always @(posedge clk) begin
    if (flash_req && !flash_we) begin
      flash_rdata <= fword(flash_addr);
      if (flash_addr != exp_rd_addr) rd_mism = rd_mism + 1;
      exp_rd_addr = exp_rd_addr + 1'b1;
      rd_cnt = rd_cnt + 1;
    end
    if (flash_req && flash_we) begin
      if (wr_cnt < 8) begin
        wr_data_log[wr_cnt] = flash_wdata;
        wr_addr_log[wr_cnt] = flash_addr;
      end
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_sel = sel;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic start_read(input logic [FADDR_W-1:0] a, input int n);
    reg_wr(2'd1, 32'(a));
    exp_rd_addr = a;
    rd_cnt = 0; rd_mism = 0;
    reg_wr(2'd0, 32'(n * 256 + 1));
  endtask

  task automatic wait_idle(output logic [31:0] c);
    c = 32'h2;
    for (int i = 0; i < 40 && c[1]; i++) reg_rd(2'd0, c);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(2'd0, d);
    chk("R1 reset control word", d, 32'h0010_0000);
    reg_rd(2'd2, d);
    chk("R1 reset data port", d, 32'h0);
    chk("R1 no flash access", {31'b0, flash_req}, 32'h0);
  endtask

  task automatic t_burst(input logic [FADDR_W-1:0] a, input int n);
    logic [31:0] d;
    start_read(a, n);
    reg_rd(2'd0, d);
    chk("R4 busy set after start", {31'b0, d[1]}, 32'h1);
    wait_idle(d);
    chk("R2 R10 control after burst", d, ctrl_exp(1, 0, n, n));
    chk("R3 read count", 32'(rd_cnt), 32'(n));
    chk("R3 consecutive addresses", 32'(rd_mism), 32'h0);
    for (int i = 0; i < n; i++) begin
      reg_rd(2'd2, d);
      chk("R5 R12 popped word", d, fword(a + FADDR_W'(i)));
    end
  endtask

  task automatic t_address_reg();
    logic [31:0] d;
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd1, 32'h0012_3456);
    reg_rd(2'd1, d);
    chk("R2 address readback", d, 32'h0012_3456);
  endtask

  task automatic t_empty_pop();
    logic [31:0] d;
    t_burst(24'h000200, 2);
    reg_rd(2'd2, d);
    chk("R6 empty pop returns zero", d, 32'h0);
    reg_rd(2'd0, d);
    chk("R6 space unchanged by empty pop", d, ctrl_exp(1, 0, 2, 0));
  endtask

  task automatic t_reject(input int n);
    logic [31:0] d;
    reg_wr(2'd0, 32'h0);
    rd_cnt = 0;
    reg_wr(2'd0, 32'(n * 256 + 1));
    repeat (5) @(negedge clk);
    reg_rd(2'd0, d);
    chk("R7 rejected start stays idle", d[1:0], 32'h0);
    chk("R7 no flash read on reject", 32'(rd_cnt), 32'h0);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    int snap;
    start_read(24'h000400, DEPTH);
    reg_wr(2'd0, 32'h0);
    snap = rd_cnt;
    repeat (6) @(negedge clk);
    chk("R8 reads stop after abort", 32'(rd_cnt), 32'(snap));
    chk("R8 burst cut short", 32'(rd_cnt < DEPTH), 32'h1);
    reg_rd(2'd0, d);
    chk("R8 idle and flushed", d, ctrl_exp(0, 0, DEPTH, 0));
    reg_rd(2'd2, d);
    chk("R8 data port empty after abort", d, 32'h0);
  endtask

  task automatic t_start_while_busy();
    logic [31:0] d;
    start_read(24'h000800, 8);
    reg_wr(2'd0, 32'(3 * 256 + 1));
    wait_idle(d);
    chk("R11 count field keeps first start", d, ctrl_exp(1, 0, 8, 8));
    chk("R11 only first burst fetched", 32'(rd_cnt), 32'h8);
    reg_rd(2'd2, d);
    chk("R11 first word of first burst", d, fword(24'h000800));
  endtask

  task automatic t_write_path();
    logic [31:0] d;
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd1, 32'h0000_0100);
    wr_cnt = 0;
    for (int i = 0; i < 3; i++) reg_wr(2'd2, 32'hA000_0000 + 32'(i));
    repeat (4) @(negedge clk);
    chk("R9 flash writes issued", 32'(wr_cnt), 32'h3);
    for (int i = 0; i < 3; i++) begin
      chk("R9 write data in order", wr_data_log[i], 32'hA000_0000 + 32'(i));
      chk("R9 write address", 32'(wr_addr_log[i]), 32'h100 + 32'(i));
    end
    reg_rd(2'd0, d);
    chk("R10 space is full depth when empty", d[31:16], 32'(DEPTH));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_address_reg();
    t_burst(24'h000010, 1);
    t_burst(24'h0000F0, 4);
    t_burst(24'hFFFFF8, DEPTH);
    t_empty_pop();
    t_reject(0);
    t_reject(DEPTH + 1);
    t_abort();
    t_start_while_busy();
    t_write_path();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule